// File: doc/BRIEF.md
# Display Link Clock Recovery Trainer

This block runs the first phase of display link training, in which the receiver is brought to bit lock on every active lane. Once started, it sets up the link by asking for four register writes in turn: the link configuration, an optional rate-index write, the channel coding select, and then a single burst that starts training pattern 1 with all lane drive levels at zero. After that it repeats a fixed loop. It waits a programmable time, reads the receiver's six status bytes, and checks lock. If the lanes are not locked, it loads new per-lane drive bytes from an external adjust merger and writes them back.

All register traffic goes through an abstract request port. The trainer holds a request steady until the responder signals completion or an error. The last status read is presented on `linkStatus` so the adjust merger can compute new drive bytes, which the trainer samples on `mergedSet`.

The phase ends with a pass when every active lane reports lock. It ends with a fail in three cases: the same lane-0 swing has been tried too many times, a pass is made after every active lane has flagged maximum swing, or any register transaction reports an error. Configuration inputs are captured when `start` is accepted. A new `start` is accepted when the trainer is idle and also after it has finished.

Top module: `crt_train_seq`

## Requirements
- R1: When start is accepted, the first request is a write to address 0x100 of length 2. Byte 0 carries the rate code. Byte 1 carries the lane count, with bit 7 set when `enhCap` is 1.
- R2: If the captured rate code is zero, the next request is a write to 0x115 of length 1 carrying `rateSelIdx`. If the rate code is nonzero, no such write is made.
- R3: Next comes a write to 0x107 of length 2 with bytes {0x00, 0x01}. It is followed by a write to 0x102 of length lane count + 1, whose byte 0 is 0x21 (pattern 1 with scrambling off) and whose remaining bytes are zero. All unused data bytes are zero.
- R4: After a pattern or lane-set write completes, the status read is requested exactly `delayCycles` + 1 clock cycles later. The read goes to 0x202 with length 6.
- R5: Lane n reports lock through bit 0 of nibble (n mod 2) of status byte n/2. The trainer finishes with a pass when every active lane reports lock. Lanes at or above the lane count are ignored.
- R6: A same-swing counter starts at 1. After each lane-set write it increments if the swing (bits 1:0) of lane 0's byte is unchanged, and reloads to 1 otherwise. The trainer fails when the counter equals 5 at a lock check that finds no lock.
- R7: A max-swing counter starts at 0. It increments after a lane-set write in which every active lane's byte has bit 2 set. The trainer fails when the counter equals 1 at a lock check that finds no lock.
- R8: If a lock check finds neither lock nor an exit condition, the trainer writes the merger's bytes for the active lanes to 0x103, with length equal to the lane count.
- R9: Any transaction answered with `regErr` ends training at once with a fail, and no further request is made.
- R10: After reset, no request is made and `busy` and `trainDone` are low. A request keeps its address and data stable until it is answered.
- R11: `start` is accepted again after a finished run. `busy` rises in the cycle after `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a training phase |
| rateCode | input | 8 | Link rate code, 0 selects the indexed rate method |
| laneCount | input | 3 | Active lane count (1, 2 or 4) |
| enhCap | input | 1 | Sink supports enhanced framing |
| rateSelIdx | input | 8 | Rate index for the indexed rate method |
| delayCycles | input | 16 | Wait before each status read, in cycles |
| regReq | output | 1 | Register transaction requested |
| regWrite | output | 1 | 1 for write, 0 for read |
| regAddr | output | 12 | Register address |
| regLen | output | 3 | Transaction length in bytes |
| regWdata | output | 40 | Write bytes, byte 0 in bits 7:0 |
| regDone | input | 1 | Transaction finished |
| regErr | input | 1 | Transaction failed |
| regRdata | input | 48 | Status bytes returned by a read |
| linkStatus | output | 48 | Last status read, to the adjust merger |
| mergedSet | input | 32 | Per-lane drive bytes from the adjust merger |
| busy | output | 1 | Training in progress |
| trainDone | output | 1 | Phase finished |
| trainPass | output | 1 | Phase finished with lock |

## Verification
The bench builds the trainer with its default parameters: four lanes, a 16-bit delay counter, a limit of 5 same-swing tries and a limit of 1 max-swing pass. It sweeps every lane count (1, 2 and 4), both enhanced-framing settings, and both zero and nonzero rate codes. Each combination is run with drive scripts that lock after a few passes, stall at one swing, reach maximum swing, or flag maximum swing on only some lanes, and with delays from 0 to 3. A second sweep injects an error at each transaction position. This covers every exit path and every request ordering.

// File: rtl/crt_pkg.sv
package crt_pkg;
  localparam int ADDR_W     = 12;
  localparam int STAT_BYTES = 6;

  localparam logic [ADDR_W-1:0] A_LINK_CFG = 12'h100;
  localparam logic [ADDR_W-1:0] A_PATTERN  = 12'h102;
  localparam logic [ADDR_W-1:0] A_LANE_SET = 12'h103;
  localparam logic [ADDR_W-1:0] A_CODING   = 12'h107;
  localparam logic [ADDR_W-1:0] A_RATE_SEL = 12'h115;
  localparam logic [ADDR_W-1:0] A_STATUS   = 12'h202;

  localparam logic [7:0] PAT1_NOSCR   = 8'h21;
  localparam logic [7:0] ENH_FRAME    = 8'h80;
  localparam logic [7:0] CODING_8B10B = 8'h01;

  localparam int MAXSW_BIT = 2;
  localparam int LOCK_BIT  = 0;

  typedef enum logic [2:0] {
    OP_NONE, OP_CFG, OP_RSEL, OP_CODE, OP_PAT, OP_STAT, OP_LANE
  } reqOp_e;

  typedef struct packed {
    logic   latchCfg;
    logic   clrTrain;
    logic   loadTrain;
    logic   initCnt;
    logic   updCnt;
    logic   loadDelay;
    logic   runDelay;
    logic   captStatus;
    reqOp_e op;
  } ctrlStrobe_t;
endpackage

// File: rtl/crt_datapath.sv
module crt_datapath
  import crt_pkg::*;
#(
  parameter int LANES       = 4,
  parameter int DLY_W       = 16,
  parameter int TRY_LIMIT   = 5,
  parameter int MAXSW_LIMIT = 1,
  localparam int LC_W   = $clog2(LANES + 1),
  localparam int WD_W   = (LANES + 1) * 8,
  localparam int STAT_W = STAT_BYTES * 8,
  localparam int LEN_MAX = (LANES + 1 > STAT_BYTES) ? LANES + 1 : STAT_BYTES,
  localparam int LEN_W  = $clog2(LEN_MAX + 1),
  localparam int TRY_W  = $clog2(TRY_LIMIT + 1),
  localparam int MSW_W  = $clog2(MAXSW_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       stb,
  input  logic [7:0]        rateCode,
  input  logic [LC_W-1:0]   laneCount,
  input  logic              enhCap,
  input  logic [7:0]        rateSelIdx,
  input  logic [DLY_W-1:0]  delayCycles,
  input  logic [STAT_W-1:0] regRdata,
  input  logic [LANES*8-1:0] mergedSet,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [LEN_W-1:0]  reqLen,
  output logic [WD_W-1:0]   reqData,
  output logic [STAT_W-1:0] statusReg,
  output logic              rateIsZero,
  output logic              delayDone,
  output logic              crOk,
  output logic              sameLimit,
  output logic              swingLimit
);
  logic [7:0]       cfgRate, cfgRsel;
  logic [LC_W-1:0]  cfgLanes;
  logic             cfgEnh;
  logic [DLY_W-1:0] cfgDelay, delayCnt;
  logic [7:0]       trainSet [LANES];
  logic [1:0]       prevSwing;
  logic [TRY_W-1:0] sameCnt;
  logic [MSW_W-1:0] maxCnt;
  logic [LANES-1:0] laneActive, laneLock, laneMax;
  logic [LANES*8-1:0] laneBytes;

  // configuration capture at start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfgRate  <= '0;
      cfgRsel  <= '0;
      cfgLanes <= '0;
      cfgEnh   <= 1'b0;
      cfgDelay <= '0;
    end else if (stb.latchCfg) begin
      cfgRate  <= rateCode;
      cfgRsel  <= rateSelIdx;
      cfgLanes <= laneCount;
      cfgEnh   <= enhCap;
      cfgDelay <= delayCycles;
    end
  end

  // per-lane decode and drive bytes
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign laneActive[l] = (LC_W'(l) < cfgLanes);
    assign laneLock[l]   = statusReg[(l / 2) * 8 + (l % 2) * 4 + LOCK_BIT];
    assign laneMax[l]    = trainSet[l][MAXSW_BIT];
    assign laneBytes[l*8 +: 8] = laneActive[l] ? trainSet[l] : 8'h00;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             trainSet[l] <= 8'h00;
      else if (stb.clrTrain)  trainSet[l] <= 8'h00;
      else if (stb.loadTrain) trainSet[l] <= mergedSet[l*8 +: 8];
    end
  end

  assign crOk       = &(~laneActive | laneLock);
  assign rateIsZero = (cfgRate == 8'h00);

  // status capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              statusReg <= '0;
    else if (stb.captStatus) statusReg <= regRdata;
  end

  // previous lane-0 swing, taken just before new settings load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             prevSwing <= 2'd0;
    else if (stb.clrTrain)  prevSwing <= 2'd0;
    else if (stb.loadTrain) prevSwing <= trainSet[0][1:0];
  end

  // exit counters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sameCnt <= TRY_W'(1);
      maxCnt  <= '0;
    end else if (stb.initCnt) begin
      sameCnt <= TRY_W'(1);
      maxCnt  <= '0;
    end else if (stb.updCnt) begin
      if (trainSet[0][1:0] == prevSwing) sameCnt <= sameCnt + TRY_W'(1);
      else                               sameCnt <= TRY_W'(1);
      if (&(~laneActive | laneMax))      maxCnt <= maxCnt + MSW_W'(1);
    end
  end

  assign sameLimit  = (sameCnt >= TRY_W'(TRY_LIMIT));
  assign swingLimit = (maxCnt >= MSW_W'(MAXSW_LIMIT));

  // wait down-counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 delayCnt <= '0;
    else if (stb.loadDelay)                     delayCnt <= cfgDelay;
    else if (stb.runDelay && delayCnt != '0)    delayCnt <= delayCnt - DLY_W'(1);
  end
  assign delayDone = (delayCnt == '0);

  // request field formation
  always_comb begin
    reqAddr = '0;
    reqLen  = '0;
    reqData = '0;
    unique case (stb.op)
      OP_CFG: begin
        reqAddr        = A_LINK_CFG;
        reqLen         = LEN_W'(2);
        reqData[7:0]   = cfgRate;
        reqData[15:8]  = 8'(cfgLanes) | (cfgEnh ? ENH_FRAME : 8'h00);
      end
      OP_RSEL: begin
        reqAddr      = A_RATE_SEL;
        reqLen       = LEN_W'(1);
        reqData[7:0] = cfgRsel;
      end
      OP_CODE: begin
        reqAddr       = A_CODING;
        reqLen        = LEN_W'(2);
        reqData[15:8] = CODING_8B10B;
      end
      OP_PAT: begin
        reqAddr           = A_PATTERN;
        reqLen            = LEN_W'(cfgLanes) + LEN_W'(1);
        reqData[7:0]      = PAT1_NOSCR;
        reqData[WD_W-1:8] = laneBytes;
      end
      OP_STAT: begin
        reqAddr = A_STATUS;
        reqLen  = LEN_W'(STAT_BYTES);
      end
      OP_LANE: begin
        reqAddr               = A_LANE_SET;
        reqLen                = LEN_W'(cfgLanes);
        reqData[LANES*8-1:0]  = laneBytes;
      end
      default: ;
    endcase
  end

  // R6: same-swing counter never passes its limit
  a_r6_same_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    sameCnt <= TRY_W'(TRY_LIMIT));
  // R7: max-swing counter never passes its limit
  a_r7_max_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    maxCnt <= MSW_W'(MAXSW_LIMIT));
  // R6/R7: counters start fresh when the loop begins
  a_r6_init: assert property (@(posedge clk) disable iff (!rst_n)
    stb.initCnt |=> (sameCnt == TRY_W'(1)) && (maxCnt == '0));
  // R4: the wait counter steps down by one while waiting
  a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.runDelay && !stb.loadDelay && delayCnt != '0) |=>
      delayCnt == $past(delayCnt) - DLY_W'(1));
endmodule

// File: rtl/crt_ctrl.sv
module crt_ctrl
  import crt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        regDone,
  input  logic        regErr,
  input  logic        rateIsZero,
  input  logic        delayDone,
  input  logic        crOk,
  input  logic        sameLimit,
  input  logic        swingLimit,
  output ctrlStrobe_t stb,
  output logic        busy,
  output logic        trainDone,
  output logic        trainPass
);
  typedef enum logic [3:0] {
    S_IDLE, S_CFG, S_RSEL, S_CODE, S_PAT, S_WAIT, S_READ, S_EVAL, S_ADJ, S_PASS, S_FAIL
  } state_e;

  state_e state, nextState;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nextState;
  end

  always_comb begin
    stb       = '0;
    stb.op    = OP_NONE;
    nextState = state;
    unique case (state)
      S_IDLE, S_PASS, S_FAIL: begin
        if (start) begin
          stb.latchCfg = 1'b1;
          stb.clrTrain = 1'b1;
          nextState    = S_CFG;
        end
      end
      S_CFG: begin
        stb.op = OP_CFG;
        if (regErr)       nextState = S_FAIL;
        else if (regDone) nextState = rateIsZero ? S_RSEL : S_CODE;
      end
      S_RSEL: begin
        stb.op = OP_RSEL;
        if (regErr)       nextState = S_FAIL;
        else if (regDone) nextState = S_CODE;
      end
      S_CODE: begin
        stb.op = OP_CODE;
        if (regErr)       nextState = S_FAIL;
        else if (regDone) nextState = S_PAT;
      end
      S_PAT: begin
        stb.op = OP_PAT;
        if (regErr) nextState = S_FAIL;
        else if (regDone) begin
          stb.initCnt   = 1'b1;
          stb.loadDelay = 1'b1;
          nextState     = S_WAIT;
        end
      end
      S_WAIT: begin
        stb.runDelay = 1'b1;
        if (delayDone) nextState = S_READ;
      end
      S_READ: begin
        stb.op = OP_STAT;
        if (regErr) nextState = S_FAIL;
        else if (regDone) begin
          stb.captStatus = 1'b1;
          nextState      = S_EVAL;
        end
      end
      S_EVAL: begin
        if (crOk)                        nextState = S_PASS;
        else if (sameLimit || swingLimit) nextState = S_FAIL;
        else begin
          stb.loadTrain = 1'b1;
          nextState     = S_ADJ;
        end
      end
      S_ADJ: begin
        stb.op = OP_LANE;
        if (regErr) nextState = S_FAIL;
        else if (regDone) begin
          stb.updCnt    = 1'b1;
          stb.loadDelay = 1'b1;
          nextState     = S_WAIT;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign trainDone = (state == S_PASS) || (state == S_FAIL);
  assign trainPass = (state == S_PASS);
  assign busy      = !trainDone && (state != S_IDLE);

  // R9: an errored transaction ends the phase with fail
  a_r9_err_fails: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.op != OP_NONE && regErr) |=> trainDone && !trainPass);
  // R5: a pass is only entered from a lock check that saw lock
  a_r5_pass_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trainPass) |-> $past(crOk) && $past(state == S_EVAL));
  // R11: busy rises one cycle after an accepted start
  a_r11_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
endmodule

// File: rtl/crt_train_seq.sv
module crt_train_seq
  import crt_pkg::*;
#(
  parameter int LANES       = 4,
  parameter int DLY_W       = 16,
  parameter int TRY_LIMIT   = 5,
  parameter int MAXSW_LIMIT = 1,
  localparam int LC_W    = $clog2(LANES + 1),
  localparam int WD_W    = (LANES + 1) * 8,
  localparam int STAT_W  = STAT_BYTES * 8,
  localparam int LEN_MAX = (LANES + 1 > STAT_BYTES) ? LANES + 1 : STAT_BYTES,
  localparam int LEN_W   = $clog2(LEN_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [7:0]         rateCode,
  input  logic [LC_W-1:0]    laneCount,
  input  logic               enhCap,
  input  logic [7:0]         rateSelIdx,
  input  logic [DLY_W-1:0]   delayCycles,
  output logic               regReq,
  output logic               regWrite,
  output logic [ADDR_W-1:0]  regAddr,
  output logic [LEN_W-1:0]   regLen,
  output logic [WD_W-1:0]    regWdata,
  input  logic               regDone,
  input  logic               regErr,
  input  logic [STAT_W-1:0]  regRdata,
  output logic [STAT_W-1:0]  linkStatus,
  input  logic [LANES*8-1:0] mergedSet,
  output logic               busy,
  output logic               trainDone,
  output logic               trainPass
);
  ctrlStrobe_t stb;
  logic rateIsZero, delayDone, crOk, sameLimit, swingLimit;

  crt_ctrl i_ctrl (
    .clk, .rst_n, .start, .regDone, .regErr, .rateIsZero, .delayDone,
    .crOk, .sameLimit, .swingLimit, .stb, .busy, .trainDone, .trainPass
  );

  crt_datapath #(
    .LANES(LANES), .DLY_W(DLY_W), .TRY_LIMIT(TRY_LIMIT), .MAXSW_LIMIT(MAXSW_LIMIT)
  ) i_dp (
    .clk, .rst_n, .stb, .rateCode, .laneCount, .enhCap, .rateSelIdx, .delayCycles,
    .regRdata, .mergedSet,
    .reqAddr(regAddr), .reqLen(regLen), .reqData(regWdata), .statusReg(linkStatus),
    .rateIsZero, .delayDone, .crOk, .sameLimit, .swingLimit
  );

  assign regReq   = (stb.op != OP_NONE);
  assign regWrite = (stb.op != OP_STAT) && regReq;

  // R10: an unanswered request holds its fields
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (regReq && !regDone && !regErr) |=>
      regReq && $stable(regAddr) && $stable(regWdata) && $stable(regLen));
  // R10: idle after reset means no request
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy) |-> !regReq);
endmodule

// File: tb/test_crt_train_seq.sv
module test_crt_train_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  rateCode = '0;
  logic [2:0]  laneCount = 3'd1;
  logic        enhCap = 1'b0;
  logic [7:0]  rateSelIdx = '0;
  logic [15:0] delayCycles = '0;
  logic        regReq, regWrite;
  logic [11:0] regAddr;
  logic [2:0]  regLen;
  logic [39:0] regWdata;
  logic        regDone = 1'b0, regErr = 1'b0;
  logic [47:0] regRdata = '0;
  logic [47:0] linkStatus;
  logic [31:0] mergedSet = '0;
  logic        busy, trainDone, trainPass;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int lastDoneEdge = 0;
  int txIdx = 0;

  crt_train_seq i_crt_train_seq (
    .clk, .rst_n, .start, .rateCode, .laneCount, .enhCap, .rateSelIdx, .delayCycles,
    .regReq, .regWrite, .regAddr, .regLen, .regWdata, .regDone, .regErr, .regRdata,
    .linkStatus, .mergedSet, .busy, .trainDone, .trainPass
  );

  always #10ns clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit cond, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // answer one transaction; dly >= 0 also checks the wait before a read
  task automatic serve(input bit expW, input logic [11:0] expA, input int expLen,
                       input logic [39:0] expD, input bit err, input logic [47:0] rd,
                       input logic [31:0] mset, input int dly, input string tag,
                       output bit ok);
    logic [63:0] act, exp;
    for (int k = 0; k < 2000 && !regReq; k++) @(negedge clk);
    if (!regReq) begin
      chk(1'b0, {tag, " no request"}, 64'd0, 64'd1);
      ok = 1'b0;
      return;
    end
    if (dly >= 0)
      chk(cyc - lastDoneEdge == dly + 1, "R4 read wait", 64'(cyc - lastDoneEdge), 64'(dly + 1));
    act = {7'd0, regWrite, regAddr, 1'b0, regLen, (regWrite ? regWdata : 40'd0)};
    exp = {7'd0, expW, expA, 1'b0, 3'(expLen), expD};
    chk(act == exp, tag, act, exp);
    @(negedge clk);
    @(negedge clk);
    regDone   = !err;
    regErr    = err;
    regRdata  = rd;
    mergedSet = mset;
    lastDoneEdge = cyc + 1;
    txIdx++;
    @(negedge clk);
    regDone = 1'b0;
    regErr  = 1'b0;
    ok = 1'b1;
  endtask

  // one training run; kind selects the drive script, errAt the failing transaction
  task automatic runOne(input int lanes, input bit enh, input logic [7:0] rate,
                        input logic [7:0] rsel, input int dly, input int kind, input int errAt);
    bit ok, stop, expPass, hitErr;
    int sameM, maxM, swing0, passAt;
    logic [47:0] st;
    logic [31:0] ms;
    logic [39:0] ed;
    laneCount   = 3'(lanes);
    enhCap      = enh;
    rateCode    = rate;
    rateSelIdx  = rsel;
    delayCycles = 16'(dly);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R11 busy after start", 64'(busy), 64'd1);
    txIdx = 0;
    stop = 0; expPass = 0; hitErr = 0;
    ed = {24'd0, 8'(lanes) | (enh ? 8'h80 : 8'h00), rate};
    serve(1, 12'h100, 2, ed, txIdx == errAt, '0, '0, -1, "R1 link config write", ok);
    if (!ok) return;
    if (errAt == txIdx - 1) begin stop = 1; hitErr = 1; end
    if (!stop && rate == 8'h00) begin
      serve(1, 12'h115, 1, {32'd0, rsel}, txIdx == errAt, '0, '0, -1, "R2 rate index write", ok);
      if (!ok) return;
      if (errAt == txIdx - 1) begin stop = 1; hitErr = 1; end
    end
    if (!stop) begin
      serve(1, 12'h107, 2, 40'h0100, txIdx == errAt, '0, '0, -1, "R2 R3 coding write", ok);
      if (!ok) return;
      if (errAt == txIdx - 1) begin stop = 1; hitErr = 1; end
    end
    if (!stop) begin
      serve(1, 12'h102, lanes + 1, 40'h21, txIdx == errAt, '0, '0, -1, "R3 pattern burst", ok);
      if (!ok) return;
      if (errAt == txIdx - 1) begin stop = 1; hitErr = 1; end
    end
    sameM = 1; maxM = 0; swing0 = 0;
    passAt = 1 + (lanes % 3);
    for (int it = 0; it < 16 && !stop; it++) begin
      bit lockNow;
      lockNow = (kind == 0) && (it == passAt);
      st = {8'hA5 ^ 8'(it), 8'h3C, 8'h5A, 8'hC3, 16'd0};
      for (int l = 0; l < 4; l++) begin
        bit act, b;
        act = (l < lanes);
        b = lockNow ? act : (act ? (l != lanes - 1) : 1'b1);
        st[(l / 2) * 8 + (l % 2) * 4] = b;
      end
      ms = '0;
      for (int l = 0; l < 4; l++) begin
        logic [7:0] by;
        case (kind)
          0: by = 8'((it + 1) % 4);
          1: by = 8'h01;
          2: by = (it >= 1) ? 8'h07 : 8'h01;
          default: by = (l == 0) ? 8'h06 : 8'h02;
        endcase
        ms[l*8 +: 8] = by;
      end
      serve(0, 12'h202, 6, 40'd0, txIdx == errAt, st, ms, dly, "R4 status read", ok);
      if (!ok) return;
      if (errAt == txIdx - 1) begin stop = 1; hitErr = 1; end
      else if (lockNow) begin stop = 1; expPass = 1; end
      else if (sameM == 5 || maxM == 1) begin stop = 1; expPass = 0; end
      else begin
        bit allMax;
        ed = '0;
        allMax = 1;
        for (int l = 0; l < lanes; l++) begin
          ed[l*8 +: 8] = ms[l*8 +: 8];
          if (!ms[l*8 + 2]) allMax = 0;
        end
        serve(1, 12'h103, lanes, ed, txIdx == errAt, '0, '0, -1, "R8 lane set write", ok);
        if (!ok) return;
        if (errAt == txIdx - 1) begin stop = 1; hitErr = 1; end
        if (int'(ms[1:0]) == swing0) sameM++;
        else sameM = 1;
        swing0 = int'(ms[1:0]);
        if (allMax) maxM++;
      end
    end
    for (int k = 0; k < 100 && !trainDone; k++) @(negedge clk);
    if (hitErr)
      chk(trainDone && !trainPass, "R9 error gives fail", {trainDone, trainPass}, 64'b10);
    else if (expPass)
      chk(trainDone && trainPass, "R5 lock gives pass", {trainDone, trainPass}, 64'b11);
    else if (maxM == 1)
      chk(trainDone && !trainPass, "R7 max swing fail", {trainDone, trainPass}, 64'b10);
    else
      chk(trainDone && !trainPass, "R6 same swing fail", {trainDone, trainPass}, 64'b10);
    chk(!regReq, "R9 R10 no request after end", 64'(regReq), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int run;
    int laneSet [3];
    laneSet[0] = 1; laneSet[1] = 2; laneSet[2] = 4;
    repeat (3) @(negedge clk);
    chk(!regReq && !busy && !trainDone, "R10 reset state",
        {regReq, busy, trainDone}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!regReq && !busy && !trainDone, "R10 idle after reset",
        {regReq, busy, trainDone}, 64'd0);
    run = 0;
    for (int li = 0; li < 3; li++)
      for (int e = 0; e < 2; e++)
        for (int r = 0; r < 2; r++)
          for (int k = 0; k < 4; k++) begin
            runOne(laneSet[li], e[0], (r == 0) ? 8'h00 : 8'h0A, 8'(3 + run), run % 4, k, -1);
            run++;
          end
    for (int li = 0; li < 3; li++)
      for (int ea = 0; ea < 7; ea++) begin
        runOne(laneSet[li], 1'b1, 8'h00, 8'h02, ea % 3, 0, ea);
        run++;
      end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule